// File: doc/BRIEF.md
# Pin-Configured Multi-Bank Clock Divider

This block takes one fast source clock and derives three bank clocks from it: bank A (five outputs in two groups), bank B (three outputs) and bank C (one differential-style output and one single-ended output). Each bank's divide ratio is picked by a pair of static three-level control pins. Odd ratios keep a balanced duty cycle through a half-cycle retimed copy. A bypass control can route a separate reference clock straight to every output, or to bank C alone.

Every control pin arrives already resolved into low, high or open. The block keeps a registered copy of the decoded controls. After power-on, and whenever any decoded control changes, it holds every divider in a common reset for a fixed number of source cycles. It then releases all of them on the same edge, so every bank starts in a known, shared phase. Per-group interface controls give an enable flag and a signalling-standard flag, and a disabled group drives its clocks low.

Top module: `mbclk_top`

## Requirements
- R1: While rst_ni is low, every clock output and every enable flag is 0. After rst_ni rises they stay 0 for RESYNC_CYC source cycles before the banks start.
- R2: Banks A and B divide the source clock by a ratio chosen by their pin pair. Pin codes are 2'b00 low, 2'b01 high, 2'b10 or 2'b11 open. Bits [3:2] of a pair carry the first pin and bits [1:0] the second. First/second pairs map to ratios as follows: low/low 2, low/high 3, high/low 4, high/high 5, high/open 6, open/high 8, low/open 10, open/low 12, open/open 15.
- R3: Bank C takes its ratio from the same nine pair codes, in the same order as R2, with ratios 5, 6, 8, 10, 12, 15, 20, 30 and 3. So open/open gives 3.
- R4: For every ratio N, the output period is N source cycles and the high time is N/2 source cycles. For odd N this is a half-cycle multiple.
- R5: A change on any decoded control drops all enable flags and clocks within two source cycles. The first rising edge of every bank then comes at the same instant, RESYNC_CYC+1 source cycles after the first source edge that sees the change.
- R6: Moving a pin between the two open codes (2'b10 and 2'b11) is not a change: no resync occurs and the enable flags stay high.
- R7: Bypass low drives every bank from its divider. Bypass high drives every output from clk_ref_i. Bypass open drives bank C from clk_ref_i and keeps A and B divided.
- R8: For each interface group (A outputs 0-2, A outputs 3-4, B, C): low gives enable 1 and pecl 0, high gives enable 1 and pecl 1, open gives enable 0 with that group's clocks held at 0. The groups are independent.
- R9: All outputs of one bank carry identical waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Fast source clock feeding the dividers |
| clk_ref_i | input | 1 | Reference clock used in bypass |
| rst_ni | input | 1 | Active-low power-on reset |
| byp_pin_i | input | 2 | Bypass control code |
| diva_pins_i | input | 4 | Bank A ratio pin pair |
| divb_pins_i | input | 4 | Bank B ratio pin pair |
| divc_pins_i | input | 4 | Bank C ratio pin pair |
| ifa_lo_pin_i | input | 2 | Interface control, A outputs 0-2 |
| ifa_hi_pin_i | input | 2 | Interface control, A outputs 3-4 |
| ifb_pin_i | input | 2 | Interface control, bank B |
| ifc_pin_i | input | 2 | Interface control, bank C |
| qa_clk_o | output | 5 | Bank A clocks |
| qb_clk_o | output | 3 | Bank B clocks |
| qc_clk_o | output | 2 | Bank C clocks (differential-style, single-ended) |
| qa_en_o | output | 2 | Bank A group enables (bit 0: outputs 0-2) |
| qa_pecl_o | output | 2 | Bank A group standard select |
| qb_en_o | output | 1 | Bank B enable |
| qb_pecl_o | output | 1 | Bank B standard select |
| qc_en_o | output | 1 | Bank C enable |
| qc_pecl_o | output | 1 | Bank C standard select |

## Verification
A wrong divider count shows up within one output period as a period or high time away from N or N/2 source cycles. A lost falling-edge copy on an odd ratio shortens the high phase by half a source cycle. A broken resync counter or change detector moves the first edge after a control change away from RESYNC_CYC+1 cycles, or leaves the banks' first edges apart. It can also leave the enables low for too long, or make them drop on an open-to-open code swap within a cycle or two. Bypass routing faults change the measured period to the reference or the divided value within a few reference periods.

// File: rtl/mbclk_pkg.sv
`timescale 1ns/1ps
package mbclk_pkg;
    localparam int RATIO_W = 5;

    typedef enum logic [1:0] {
        LV_LO = 2'b00,
        LV_HI = 2'b01,
        LV_OP = 2'b10
    } lvl_t;

    typedef struct packed {
        lvl_t byp;
        lvl_t da1;
        lvl_t da0;
        lvl_t db1;
        lvl_t db0;
        lvl_t dc1;
        lvl_t dc0;
        lvl_t ia_lo;
        lvl_t ia_hi;
        lvl_t ib;
        lvl_t ic;
    } cfg_t;

    // both 2'b10 and 2'b11 resolve to open
    function automatic lvl_t lvl_of(input logic [1:0] pin);
        lvl_t v;
        if (pin[1])      v = LV_OP;
        else if (pin[0]) v = LV_HI;
        else             v = LV_LO;
        return v;
    endfunction

    // position of a pin pair within the shared nine-entry ratio order
    function automatic logic [3:0] pair_idx(input lvl_t first, input lvl_t second);
        logic [3:0] idx;
        case ({first, second})
            4'b0000: idx = 4'd0;
            4'b0001: idx = 4'd1;
            4'b0100: idx = 4'd2;
            4'b0101: idx = 4'd3;
            4'b0110: idx = 4'd4;
            4'b1001: idx = 4'd5;
            4'b0010: idx = 4'd6;
            4'b1000: idx = 4'd7;
            default: idx = 4'd8;
        endcase
        return idx;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_ab(input logic [3:0] idx);
        logic [RATIO_W-1:0] r;
        case (idx)
            4'd0: r = RATIO_W'(2);
            4'd1: r = RATIO_W'(3);
            4'd2: r = RATIO_W'(4);
            4'd3: r = RATIO_W'(5);
            4'd4: r = RATIO_W'(6);
            4'd5: r = RATIO_W'(8);
            4'd6: r = RATIO_W'(10);
            4'd7: r = RATIO_W'(12);
            default: r = RATIO_W'(15);
        endcase
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_c(input logic [3:0] idx);
        logic [RATIO_W-1:0] r;
        case (idx)
            4'd0: r = RATIO_W'(5);
            4'd1: r = RATIO_W'(6);
            4'd2: r = RATIO_W'(8);
            4'd3: r = RATIO_W'(10);
            4'd4: r = RATIO_W'(12);
            4'd5: r = RATIO_W'(15);
            4'd6: r = RATIO_W'(20);
            4'd7: r = RATIO_W'(30);
            default: r = RATIO_W'(3);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mbclk_resync.sv
`timescale 1ns/1ps
module mbclk_resync
    import mbclk_pkg::*;
#(
    parameter int RESYNC_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  cfg_t cfg_i,
    output cfg_t cfg_o,
    output logic hold_o
);
    localparam int HW = $clog2(RESYNC_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(RESYNC_CYC);

    typedef struct packed {
        cfg_t          cfg;
        logic [HW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cfg = cfg_i;
        if (cfg_i != s_q.cfg) begin
            s_d.cnt = HOLD_LOAD;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cfg <= '0;
            s_q.cnt <= HOLD_LOAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o  = s_q.cfg;
    assign hold_o = (s_q.cnt != '0);

    // R5: any decoded control change restarts the full hold window
    p_change_reloads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i != s_q.cfg) |=> (hold_o && s_q.cnt == HOLD_LOAD));

    // R6: a settled, unchanged configuration never re-enters hold
    p_settled_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_o && cfg_i == s_q.cfg) |=> !hold_o);
endmodule

// File: rtl/mbclk_div.sv
`timescale 1ns/1ps
module mbclk_div
    import mbclk_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hold_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               clk_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               ph;
    } st_t;

    st_t                s_d, s_q;
    logic [RATIO_W-1:0] last;
    logic [RATIO_W-1:0] half;
    logic               odd;
    logic               ph_n_q;

    always_comb begin
        odd  = ratio_i[0];
        last = ratio_i - 1'b1;
        half = ratio_i >> 1;   // N/2 for even, (N-1)/2 for odd
        s_d  = s_q;
        if (hold_i) begin
            s_d.cnt = last;    // first released edge wraps to 0
            s_d.ph  = 1'b0;
        end else begin
            s_d.cnt = (s_q.cnt >= last) ? '0 : s_q.cnt + 1'b1;
            s_d.ph  = (s_d.cnt < half);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // half-cycle retimed copy stretches odd high phases by 0.5 cycle
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_n_q <= 1'b0;
        end else begin
            ph_n_q <= s_q.ph;
        end
    end

    assign clk_o = s_q.ph | (odd & ph_n_q);

    // R4: the counter stays inside the selected ratio while running
    p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hold_i |-> (s_q.cnt <= last));

    // R5: the first edge after release is a rising one
    p_first_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hold_i) |=> s_q.ph);

    // R1: the phase register is quiet throughout a hold
    p_quiet_in_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> !s_q.ph);
endmodule

// File: rtl/mbclk_top.sv
`timescale 1ns/1ps
module mbclk_top
    import mbclk_pkg::*;
#(
    parameter int RESYNC_CYC = 8
) (
    input  logic       clk_src_i,
    input  logic       clk_ref_i,
    input  logic       rst_ni,
    input  logic [1:0] byp_pin_i,
    input  logic [3:0] diva_pins_i,
    input  logic [3:0] divb_pins_i,
    input  logic [3:0] divc_pins_i,
    input  logic [1:0] ifa_lo_pin_i,
    input  logic [1:0] ifa_hi_pin_i,
    input  logic [1:0] ifb_pin_i,
    input  logic [1:0] ifc_pin_i,
    output logic [4:0] qa_clk_o,
    output logic [2:0] qb_clk_o,
    output logic [1:0] qc_clk_o,
    output logic [1:0] qa_en_o,
    output logic [1:0] qa_pecl_o,
    output logic       qb_en_o,
    output logic       qb_pecl_o,
    output logic       qc_en_o,
    output logic       qc_pecl_o
);
    localparam int NBANK = 3;

    cfg_t               cfg_d;
    cfg_t               cfg_q;
    logic               hold;
    logic [RATIO_W-1:0] bank_ratio [NBANK];
    logic [NBANK-1:0]   div_clk;
    logic               src_a, src_b, src_c;
    logic               byp_all, byp_c;

    always_comb begin
        cfg_d.byp   = lvl_of(byp_pin_i);
        cfg_d.da1   = lvl_of(diva_pins_i[3:2]);
        cfg_d.da0   = lvl_of(diva_pins_i[1:0]);
        cfg_d.db1   = lvl_of(divb_pins_i[3:2]);
        cfg_d.db0   = lvl_of(divb_pins_i[1:0]);
        cfg_d.dc1   = lvl_of(divc_pins_i[3:2]);
        cfg_d.dc0   = lvl_of(divc_pins_i[1:0]);
        cfg_d.ia_lo = lvl_of(ifa_lo_pin_i);
        cfg_d.ia_hi = lvl_of(ifa_hi_pin_i);
        cfg_d.ib    = lvl_of(ifb_pin_i);
        cfg_d.ic    = lvl_of(ifc_pin_i);
    end

    mbclk_resync #(.RESYNC_CYC(RESYNC_CYC)) u_resync (
        .clk_i  (clk_src_i),
        .rst_ni (rst_ni),
        .cfg_i  (cfg_d),
        .cfg_o  (cfg_q),
        .hold_o (hold)
    );

    always_comb begin
        bank_ratio[0] = ratio_ab(pair_idx(cfg_q.da1, cfg_q.da0));
        bank_ratio[1] = ratio_ab(pair_idx(cfg_q.db1, cfg_q.db0));
        bank_ratio[2] = ratio_c(pair_idx(cfg_q.dc1, cfg_q.dc0));
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        mbclk_div u_div (
            .clk_i   (clk_src_i),
            .rst_ni  (rst_ni),
            .hold_i  (hold),
            .ratio_i (bank_ratio[g]),
            .clk_o   (div_clk[g])
        );
    end

    always_comb begin
        byp_all   = (cfg_q.byp == LV_HI);
        byp_c     = (cfg_q.byp != LV_LO);
        src_a     = byp_all ? clk_ref_i : div_clk[0];
        src_b     = byp_all ? clk_ref_i : div_clk[1];
        src_c     = byp_c   ? clk_ref_i : div_clk[2];

        qa_en_o[0]   = (cfg_q.ia_lo != LV_OP) && !hold;
        qa_en_o[1]   = (cfg_q.ia_hi != LV_OP) && !hold;
        qb_en_o      = (cfg_q.ib != LV_OP) && !hold;
        qc_en_o      = (cfg_q.ic != LV_OP) && !hold;
        qa_pecl_o[0] = (cfg_q.ia_lo == LV_HI);
        qa_pecl_o[1] = (cfg_q.ia_hi == LV_HI);
        qb_pecl_o    = (cfg_q.ib == LV_HI);
        qc_pecl_o    = (cfg_q.ic == LV_HI);

        qa_clk_o = {{2{src_a & qa_en_o[1]}}, {3{src_a & qa_en_o[0]}}};
        qb_clk_o = {3{src_b & qb_en_o}};
        qc_clk_o = {2{src_c & qc_en_o}};
    end
endmodule

// File: tb/sim_mbclk_top.sv
`timescale 1ns/1ps
module sim_mbclk_top;
    localparam int RS = 8;
    localparam logic [3:0] CODES [9] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101,
                                         4'b0110, 4'b1001, 4'b0010, 4'b1000, 4'b1010};

    logic clk_src = 1'b0, clk_ref = 1'b0, rst_n = 1'b0;
    logic [1:0] byp = 2'b00, ifa_lo = 2'b00, ifa_hi = 2'b00, ifb = 2'b00, ifc = 2'b00;
    logic [3:0] diva = 4'b0000, divb = 4'b0000, divc = 4'b0000;
    logic [4:0] qa_clk;
    logic [2:0] qb_clk;
    logic [1:0] qc_clk, qa_en, qa_pecl;
    logic       qb_en, qb_pecl, qc_en, qc_pecl;

    always #2 clk_src = ~clk_src;
    always #15 clk_ref = ~clk_ref;

    mbclk_top #(.RESYNC_CYC(RS)) u0 (
        .clk_src_i(clk_src), .clk_ref_i(clk_ref), .rst_ni(rst_n),
        .byp_pin_i(byp), .diva_pins_i(diva), .divb_pins_i(divb), .divc_pins_i(divc),
        .ifa_lo_pin_i(ifa_lo), .ifa_hi_pin_i(ifa_hi), .ifb_pin_i(ifb), .ifc_pin_i(ifc),
        .qa_clk_o(qa_clk), .qb_clk_o(qb_clk), .qc_clk_o(qc_clk),
        .qa_en_o(qa_en), .qa_pecl_o(qa_pecl), .qb_en_o(qb_en), .qb_pecl_o(qb_pecl),
        .qc_en_o(qc_en), .qc_pecl_o(qc_pecl)
    );

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    real ra = 0, pa = 0, ha = 0, rb = 0, pb = 0, hb = 0, rc = 0, pc = 0, hc = 0;

    always @(posedge qa_clk[0]) begin pa = $realtime - ra; ra = $realtime; end
    always @(negedge qa_clk[0]) ha = $realtime - ra;
    always @(posedge qb_clk[0]) begin pb = $realtime - rb; rb = $realtime; end
    always @(negedge qb_clk[0]) hb = $realtime - rb;
    always @(posedge qc_clk[0]) begin pc = $realtime - rc; rc = $realtime; end
    always @(negedge qc_clk[0]) hc = $realtime - rc;

    function automatic real exp_ab(input int i);
        int t [9] = '{2, 3, 4, 5, 6, 8, 10, 12, 15};
        return real'(t[i]);
    endfunction

    function automatic real exp_c(input int i);
        int t [9] = '{5, 6, 8, 10, 12, 15, 20, 30, 3};
        return real'(t[i]);
    endfunction

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_src);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk(qa_clk == 0 && qb_clk == 0 && qc_clk == 0, "R1", "clocks in reset",
            real'(qa_clk), 0.0);
        chk(qa_en == 0 && !qb_en && !qc_en, "R1", "enables in reset", real'(qa_en), 0.0);
        rst_n = 1'b1;
        step(2);
        chk(qa_en == 0 && !qb_en && !qc_en, "R1", "enables during post-reset hold",
            real'(qa_en), 0.0);
        step(RS + 4);
        chk(qa_en == 2'b11 && qb_en && qc_en, "R1", "enables after hold", real'(qa_en), 3.0);
        chk(qa_pecl == 2'b00 && !qb_pecl && !qc_pecl, "R8", "low selects pecl 0",
            real'(qa_pecl), 0.0);
    endtask

    task automatic t_ratios();
        for (int i = 0; i < 9; i++) begin
            diva = CODES[i]; divb = CODES[i]; divc = CODES[i];
            step(130);
            chk(near(pa, 4.0 * exp_ab(i)), "R2", "A period", pa, 4.0 * exp_ab(i));
            chk(near(ha, 2.0 * exp_ab(i)), "R4", "A high time", ha, 2.0 * exp_ab(i));
            chk(near(pb, 4.0 * exp_ab(i)), "R2", "B period", pb, 4.0 * exp_ab(i));
            chk(near(hb, 2.0 * exp_ab(i)), "R4", "B high time", hb, 2.0 * exp_ab(i));
            chk(near(pc, 4.0 * exp_c(i)), "R3", "C period", pc, 4.0 * exp_c(i));
            chk(near(hc, 2.0 * exp_c(i)), "R4", "C high time", hc, 2.0 * exp_c(i));
        end
    endtask

    task automatic t_resync();
        real t0, fa, fb, fc;
        bit  same_a, same_b, same_c;
        divb = CODES[5];
        t0 = $realtime;
        step(2);
        chk(qa_en == 0 && !qb_en && !qc_en, "R5", "enables drop on change", real'(qa_en), 0.0);
        chk(qa_clk == 0 && qb_clk == 0 && qc_clk == 0, "R5", "clocks low in hold",
            real'(qa_clk), 0.0);
        fa = 0; fb = 0; fc = 0;
        fork
            begin @(posedge qa_clk[0]); fa = $realtime; end
            begin @(posedge qb_clk[0]); fb = $realtime; end
            begin @(posedge qc_clk[0]); fc = $realtime; end
        join
        chk(near(fa, t0 + 3.0 + 4.0 * (RS + 1)), "R5", "first edge time", fa,
            t0 + 3.0 + 4.0 * (RS + 1));
        chk(near(fa, fb), "R5", "A/B first edges aligned", fb, fa);
        chk(near(fa, fc), "R5", "A/C first edges aligned", fc, fa);
        same_a = 1; same_b = 1; same_c = 1;
        for (int k = 0; k < 80; k++) begin
            #1;
            if (qa_clk != 5'b00000 && qa_clk != 5'b11111) same_a = 0;
            if (qb_clk != 3'b000 && qb_clk != 3'b111) same_b = 0;
            if (qc_clk != 2'b00 && qc_clk != 2'b11) same_c = 0;
            #1;
        end
        chk(same_a, "R9", "bank A outputs identical", real'(same_a), 1.0);
        chk(same_b, "R9", "bank B outputs identical", real'(same_b), 1.0);
        chk(same_c, "R9", "bank C outputs identical", real'(same_c), 1.0);
    endtask

    task automatic t_alias();
        bit steady;
        step(20);
        diva = 4'b1111;
        steady = 1;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (!(qa_en == 2'b11 && qb_en && qc_en)) steady = 0;
        end
        chk(steady, "R6", "open code swap keeps enables", real'(steady), 1.0);
        step(40);
        chk(near(pa, 60.0), "R6", "A ratio unchanged", pa, 60.0);
    endtask

    task automatic t_bypass();
        byp = 2'b01;
        step(130);
        chk(near(pa, 30.0) && near(ha, 15.0), "R7", "bypass high A follows ref", pa, 30.0);
        chk(near(pb, 30.0), "R7", "bypass high B follows ref", pb, 30.0);
        chk(near(pc, 30.0), "R7", "bypass high C follows ref", pc, 30.0);
        byp = 2'b10;
        step(130);
        chk(near(pa, 60.0), "R7", "bypass open A divided", pa, 60.0);
        chk(near(pb, 32.0), "R7", "bypass open B divided", pb, 32.0);
        chk(near(pc, 30.0), "R7", "bypass open C follows ref", pc, 30.0);
        byp = 2'b00;
        step(130);
        chk(near(pc, 12.0) && near(hc, 6.0), "R7", "bypass low C divided", pc, 12.0);
    endtask

    task automatic t_iface();
        bit lo_quiet, hi_active, c_quiet;
        ifa_lo = 2'b10;
        step(20);
        chk(qa_en == 2'b10 && qa_pecl == 2'b00, "R8", "A group 0-2 disabled",
            real'(qa_en), 2.0);
        lo_quiet = 1; hi_active = 0;
        for (int k = 0; k < 60; k++) begin
            #2;
            if (qa_clk[2:0] != 3'b000) lo_quiet = 0;
            if (qa_clk[4:3] != 2'b00) hi_active = 1;
        end
        chk(lo_quiet, "R8", "disabled group held low", real'(lo_quiet), 1.0);
        chk(hi_active, "R8", "other A group still clocks", real'(hi_active), 1.0);
        ifb = 2'b01; ifa_hi = 2'b01;
        step(20);
        chk(qb_en && qb_pecl, "R8", "B high selects pecl", real'(qb_pecl), 1.0);
        chk(qa_en == 2'b10 && qa_pecl == 2'b10, "R8", "A group 3-4 pecl", real'(qa_pecl), 2.0);
        ifc = 2'b11;
        step(20);
        chk(!qc_en && !qc_pecl, "R8", "C open disabled", real'(qc_en), 0.0);
        c_quiet = 1;
        for (int k = 0; k < 40; k++) begin
            #2;
            if (qc_clk != 2'b00) c_quiet = 0;
        end
        chk(c_quiet, "R8", "disabled C held low", real'(c_quiet), 1.0);
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_resync();
        t_alias();
        t_bypass();
        t_iface();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule